// File: doc/BRIEF.md
# Serial slave pause gate

This block sits between the pins of a serial slave port and the shift logic behind it. It brings the select, clock, pause and data-in pins into the fast system clock domain and finds the serial clock edges. It passes those edges to the shift logic as one-cycle strobes, but only while the port is selected and not paused. While paused, the block blocks the strobes, keeps the received bit and the bit position, and turns off the data-out driver. The serial clock may keep toggling during a pause, and the transfer continues at the same bit once the pause ends.

The pause input counts only while the port is selected. It is looked at only while the synchronised serial clock is low. A pause edge that arrives while the clock is high takes effect at the next low phase. Deselecting the port clears the pause and the bit position, so every new selection starts unpaused at bit zero. The system clock must run at least four times faster than the serial clock.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset, paused_o, so_oe_o, so_o, sample_stb_o and shift_stb_o are 0, and bit_cnt_o and si_bit_o are 0.
- R2: Each pin passes through two synchronising flops. While the port is selected and not paused, a rise of sck_i gives sample_stb_o, and a fall gives shift_stb_o. Each strobe is high for exactly one cycle, starting after the second clock edge that follows the pin change.
- R3: While selected, a low hold_n_i seen while the synchronised clock is low sets paused_o one clock later.
- R4: While paused, a high hold_n_i seen while the synchronised clock is low clears paused_o. The next clock edges are then counted from the bit where the pause began.
- R5: While paused, serial clock edges give no strobe, and bit_cnt_o and si_bit_o do not change.
- R6: so_oe_o is 1 only while the port is selected, not paused and so_req_i is 1. so_o equals so_bit_i while so_oe_o is 1 and is 0 otherwise.
- R7: A hold_n_i change made while the synchronised clock is high does not change paused_o until the clock has gone low again.
- R8: While cs_n_i is high (synchronised), paused_o is cleared, bit_cnt_o returns to 0 and no strobe is produced.
- R9: A low hold_n_i has no effect while the port is deselected.
- R10: bit_cnt_o adds one on every sample strobe and wraps modulo 2^CNT_W. si_bit_o takes the synchronised data-in level on every sample strobe.
- R11: If a serial clock rise and a hold_n_i fall reach the synchronisers in the same cycle, the rise is still counted. The pause starts once the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| hold_n_i | input | 1 | Pause pin, active low |
| si_i | input | 1 | Serial data-in pin |
| so_bit_i | input | 1 | Data-out bit from the shift logic |
| so_req_i | input | 1 | Shift logic wants to drive data-out |
| sample_stb_o | output | 1 | Qualified serial clock rise strobe |
| shift_stb_o | output | 1 | Qualified serial clock fall strobe |
| si_bit_o | output | 1 | Data-in bit captured on the last sample strobe |
| bit_cnt_o | output | CNT_W | Bit position within the current word |
| so_o | output | 1 | Data-out value toward the pad |
| so_oe_o | output | 1 | Data-out driver enable (0 = high impedance) |
| paused_o | output | 1 | Port is paused |

## Verification
Two functions can land in the same system cycle: a serial clock edge being passed on, and a pause edge being taken. The bench provokes this by changing sck_i and hold_n_i on the same system clock edge, and also by dropping hold_n_i while the clock is high. A behavioural model, run every cycle, judges the result: the clock rise must still be counted, and the pause must start only after the clock is back low. Directed checks then confirm the absolute bit count and the captured data bit at each step.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic hold_n;
        logic si;
    } pin_vec_t;

    localparam int PIN_W = $bits(pin_vec_t);

    // levels the pins sit at when idle; used as synchroniser reset value
    localparam pin_vec_t PIN_IDLE = '{cs_n: 1'b1, sck: 1'b0, hold_n: 1'b1, si: 1'b0};

    typedef struct packed {
        logic paused;
    } pause_st_t;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[LAST];

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
    parameter int              WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            assign rise[g] = lvl[g] & ~prev_q[g];
            assign fall[g] = ~lvl[g] & prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/spi_hold_pause_ctrl.sv
module spi_hold_pause_ctrl
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,       // synchronised select, active high
    input  logic sck_lvl,   // synchronised serial clock level
    input  logic hold_n_lvl,// synchronised pause pin, active low
    output logic paused
);
    pause_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sel) begin
            st_d.paused = 1'b0;
        end else if (!sck_lvl) begin
            // pause level is only looked at during the clock low phase
            st_d.paused = ~hold_n_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign paused = st_q.paused;

    AST_PAUSE_ENTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.paused) |-> $past(!sck_lvl && sel)) else $error("pause entered outside clock low"); // R3
    AST_PAUSE_LEAVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.paused) && $past(sel)) |-> $past(!sck_lvl)) else $error("pause left outside clock low"); // R7
    AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !st_q.paused) else $error("pause survived deselect"); // R8

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             sck_i,
    input  logic             hold_n_i,
    input  logic             si_i,
    input  logic             so_bit_i,
    input  logic             so_req_i,
    output logic             sample_stb_o,
    output logic             shift_stb_o,
    output logic             si_bit_o,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic             so_o,
    output logic             so_oe_o,
    output logic             paused_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             si;
    } core_st_t;

    pin_vec_t  pin_raw, pin_s;
    logic      sel;
    logic      sck_rise, sck_fall;
    logic      paused;
    logic      samp_ok, shift_ok;
    core_st_t  core_d, core_q;

    assign pin_raw = '{cs_n: cs_n_i, sck: sck_i, hold_n: hold_n_i, si: si_i};

    spi_hold_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_raw),
        .dout  (pin_s)
    );

    spi_hold_edge #(
        .WIDTH   (1),
        .RST_VAL (PIN_IDLE.sck)
    ) u_sck_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_s.sck),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    assign sel = ~pin_s.cs_n;

    spi_hold_pause_ctrl u_pause (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .sck_lvl    (pin_s.sck),
        .hold_n_lvl (pin_s.hold_n),
        .paused     (paused)
    );

    assign samp_ok  = sck_rise & sel & ~paused;
    assign shift_ok = sck_fall & sel & ~paused;

    always_comb begin
        core_d = core_q;
        if (!sel) begin
            core_d.cnt = '0;
        end else if (samp_ok) begin
            core_d.cnt = core_q.cnt + CNT_ONE;
            core_d.si  = pin_s.si;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign sample_stb_o = samp_ok;
    assign shift_stb_o  = shift_ok;
    assign si_bit_o     = core_q.si;
    assign bit_cnt_o    = core_q.cnt;
    assign paused_o     = paused;
    assign so_oe_o      = sel & ~paused & so_req_i;
    assign so_o         = so_oe_o & so_bit_i;

    AST_NO_STB_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !(sample_stb_o || shift_stb_o)) else $error("strobe while paused"); // R5
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && sel) |=> ($stable(bit_cnt_o) && $stable(si_bit_o))) else $error("state moved while paused"); // R5
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (paused || !sel) |-> !so_oe_o) else $error("driver on while paused or idle"); // R6
    AST_NO_STB_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !(sample_stb_o || shift_stb_o)) else $error("strobe while deselected"); // R8
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sample_stb_o, shift_stb_o}) <= 1) else $error("both strobes"); // R2

endmodule

// File: tb/spi_hold_gate_bench.sv
module spi_hold_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 3;
    localparam int HALF       = 4;
    localparam int WD_LIMIT   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
    logic so_bit = 1'b0, so_req = 1'b1;
    logic samp, shft, si_bit, so, so_oe, paused;
    logic [CNT_W-1:0] cnt;

    int checks = 0, fails = 0, cycles = 0;
    int samp_seen = 0, shift_seen = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_hold_gate #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u_spi_hold_gate (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .hold_n_i(hold_n),
        .si_i(si), .so_bit_i(so_bit), .so_req_i(so_req),
        .sample_stb_o(samp), .shift_stb_o(shft), .si_bit_o(si_bit),
        .bit_cnt_o(cnt), .so_o(so), .so_oe_o(so_oe), .paused_o(paused));

    // behavioural reference: pin history queues and integers
    bit q_cs[$], q_sck[$], q_hold[$], q_si[$];
    bit m_sck_prev;
    bit m_pause;
    int m_cnt;
    bit m_si;

    function automatic bit m_sel();      return !q_cs[1];                          endfunction
    function automatic bit m_rise();     return q_sck[1] && !m_sck_prev;           endfunction
    function automatic bit m_fall();     return !q_sck[1] && m_sck_prev;           endfunction
    function automatic bit m_samp();     return m_rise() && m_sel() && !m_pause;   endfunction
    function automatic bit m_shift();    return m_fall() && m_sel() && !m_pause;   endfunction

    task automatic model_reset();
        q_cs = '{1, 1}; q_sck = '{0, 0}; q_hold = '{1, 1}; q_si = '{0, 0};
        m_sck_prev = 0; m_pause = 0; m_cnt = 0; m_si = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit nsamp, npause;
            int ncnt;
            nsamp  = m_samp();
            npause = m_pause;
            ncnt   = m_cnt;
            if (!m_sel()) begin
                npause = 0; ncnt = 0;
            end else begin
                if (!q_sck[1]) npause = !q_hold[1];
                if (nsamp) begin ncnt = (m_cnt + 1) % (1 << CNT_W); m_si = q_si[1]; end
            end
            m_sck_prev = q_sck[1];
            m_pause = npause;
            m_cnt   = ncnt;
            void'(q_cs.pop_back());   q_cs.push_front(cs_n);
            void'(q_sck.pop_back());  q_sck.push_front(sck);
            void'(q_hold.pop_back()); q_hold.push_front(hold_n);
            void'(q_si.pop_back());   q_si.push_front(si);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_oe;
            exp_oe = m_sel() && !m_pause && so_req;
            chk("R2 model sample_stb", samp, m_samp());
            chk("R2 model shift_stb", shft, m_shift());
            chk("R3 model paused", paused, m_pause);
            chk("R10 model bit_cnt", cnt, m_cnt);
            chk("R10 model si_bit", si_bit, m_si);
            chk("R6 model so_oe", so_oe, exp_oe);
            chk("R6 model so", so, exp_oe && so_bit);
            if (samp) samp_seen++;
            if (shft) shift_seen++;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        sck = 1'b1; wait_n(HALF);
        sck = 1'b0; wait_n(HALF);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
            finish_run();
        end
    end

    initial begin
        int s0, f0;
        wait_n(3);
        // R1 reset state
        chk("R1 paused", paused, 0);
        chk("R1 so_oe", so_oe, 0);
        chk("R1 so", so, 0);
        chk("R1 bit_cnt", cnt, 0);
        chk("R1 sample_stb", samp, 0);
        rst_n = 1'b1;
        wait_n(2);

        // R2 / R10 select and clock three bits with SI high
        cs_n = 1'b0; si = 1'b1; so_bit = 1'b1; wait_n(4);
        chk("R6 driver on when selected", so_oe, 1);
        chk("R6 so follows bit", so, 1);
        s0 = samp_seen; f0 = shift_seen;
        repeat (3) pulse();
        wait_n(3);
        chk("R2 one sample strobe per rise", samp_seen - s0, 3);
        chk("R2 one shift strobe per fall", shift_seen - f0, 3);
        chk("R10 bit_cnt after three", cnt, 3);
        chk("R10 si captured", si_bit, 1);

        // R3 pause while clock low
        hold_n = 1'b0; wait_n(4);
        chk("R3 paused", paused, 1);
        chk("R6 driver off while paused", so_oe, 0);
        chk("R6 so low while paused", so, 0);
        // R5 clock and data keep moving
        s0 = samp_seen; si = 1'b0;
        repeat (4) pulse();
        chk("R5 no strobes while paused", samp_seen - s0, 0);
        chk("R5 bit_cnt frozen", cnt, 3);
        chk("R5 si_bit frozen", si_bit, 1);

        // R4 resume where it stopped, R10 wrap
        hold_n = 1'b1; wait_n(4);
        chk("R4 resumed", paused, 0);
        repeat (5) pulse();
        wait_n(3);
        chk("R4 R10 bit_cnt wraps to 0", cnt, 0);
        chk("R10 si zero captured", si_bit, 0);

        // R7 pause edge during clock high is deferred
        sck = 1'b1; wait_n(6);
        hold_n = 1'b0; wait_n(8);
        chk("R7 no pause during high", paused, 0);
        chk("R7 rise counted", cnt, 1);
        sck = 1'b0; wait_n(6);
        chk("R7 pause after low", paused, 1);
        sck = 1'b1; wait_n(6);
        hold_n = 1'b1; wait_n(8);
        chk("R7 no resume during high", paused, 1);
        sck = 1'b0; wait_n(6);
        chk("R7 resume after low", paused, 0);
        chk("R7 count kept", cnt, 1);

        // R11 clock rise and pause fall on the same edge
        sck = 1'b1; hold_n = 1'b0; wait_n(6);
        chk("R11 rise counted", cnt, 2);
        chk("R11 pause deferred", paused, 0);
        sck = 1'b0; wait_n(6);
        chk("R11 paused after low", paused, 1);

        // R8 deselect clears pause and count
        cs_n = 1'b1; wait_n(6);
        chk("R8 pause cleared", paused, 0);
        chk("R8 bit_cnt cleared", cnt, 0);
        chk("R8 driver off", so_oe, 0);
        // R9 pause pin ignored when idle; R8 no strobes
        s0 = samp_seen;
        repeat (3) pulse();
        chk("R9 still unpaused", paused, 0);
        chk("R8 no strobes deselected", samp_seen - s0, 0);
        chk("R8 count stays 0", cnt, 0);

        // reselect with pause pin low: takes effect since clock low
        cs_n = 1'b0; wait_n(6);
        chk("R3 pause on reselect", paused, 1);
        hold_n = 1'b1; so_req = 1'b0; wait_n(6);
        chk("R6 no request no drive", so_oe, 0);
        so_req = 1'b1; so_bit = 1'b0; wait_n(2);
        chk("R6 so follows low bit", so, 0);
        chk("R6 driver on", so_oe, 1);
        cs_n = 1'b1; wait_n(6);
        finish_run();
    end

endmodule